// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Responder

This block sits on the device side of a processor bus and answers interrupt acknowledge cycles. The device raises a request with a pulse on `irq_set_i`, and the block holds that request as pending. When the core starts a bus cycle with all function-code bits high, the low address lines give the priority level being acknowledged. If the level matches the level configured for this device and a request is pending, the block answers the cycle. It does so in one of two ways, chosen by configuration.

In vectored mode the block drives an 8-bit exception vector number onto the data bus and asserts an active-low data-valid strobe. In autovector mode it leaves the bus undriven and asserts an active-low autovector strobe, so the core uses the fixed vector for that level. In both modes the block also reports the vector number the core will use and the byte address of that entry in the vector table.

The strobe stays asserted until the address strobe is released. The pending request is cleared at the end of the answered cycle. Cycles that do not match are ignored and leave the pending request in place.

Top module: `iack_responder`

## Requirements
- R1: After reset, `irq_pending_o` is 0, `data_oe_o` is 0 and both `dtack_no` and `avec_no` are 1.
- R2: A one-cycle pulse on `irq_set_i` sets `irq_pending_o` to 1 at the next clock edge. The request then stays set until a matched acknowledge cycle ends.
- R3: The block answers only when all of the following hold at a clock edge: `as_ni` is 0, `fc_i` is 3'b111, `addr_i` (address bits A3..A1, with A1 in bit 0) equals `cfg_level_i`, `cfg_level_i` is not 0, and a request is pending. Any other cycle leaves both strobes at 1, `data_oe_o` at 0 and the pending request unchanged.
- R4: A strobe goes low at the first clock edge after the edge where the matching cycle is sampled, and not before it.
- R5: In vectored mode (`cfg_autovec_i` = 0), a matched cycle drives `dtack_no` to 0, `avec_no` to 1 and `data_oe_o` to 1, and puts the vector number on `data_o`. A configured vector from 64 to 255 is passed through unchanged.
- R6: In vectored mode, a configured vector below 64 is replaced by the vector number 15.
- R7: In autovector mode (`cfg_autovec_i` = 1), a matched cycle drives `avec_no` to 0, `dtack_no` to 1 and `data_oe_o` to 0. The reported vector number is 24 plus the level.
- R8: While a strobe is asserted, `vec_addr_o` equals `vec_num_o` times 4.
- R9: A strobe stays low while `as_ni` stays 0. It is released at the first clock edge where `as_ni` is sampled as 1. At that same edge the pending request is cleared, unless `irq_set_i` is 1.
- R10: `dtack_no` and `avec_no` are never 0 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_set_i | input | 1 | Raises the device's interrupt request |
| cfg_level_i | input | 3 | Priority level this device interrupts on (0 disables answering) |
| cfg_vector_i | input | 8 | Vector number used in vectored mode |
| cfg_autovec_i | input | 1 | 1 selects autovector mode, 0 selects vectored mode |
| fc_i | input | 3 | Function-code lines from the core |
| addr_i | input | 3 | Address bits A3..A1 |
| as_ni | input | 1 | Address strobe, active low |
| data_o | output | 8 | Low data byte driven during a vectored answer |
| data_oe_o | output | 1 | Output enable for `data_o` |
| dtack_no | output | 1 | Data-valid strobe, active low |
| avec_no | output | 1 | Autovector strobe, active low |
| irq_pending_o | output | 1 | The device's pending request |
| vec_num_o | output | 8 | Vector number for the current answer |
| vec_addr_o | output | 10 | Vector table byte address for the current answer |

## Verification
The hardest case to reach is a cycle that matches in every respect but one. The request is pending and the level fits, but the function code is wrong, or the address names another level. The check is that the request survives such a cycle. To reach it, the stimulus raises a request first and then sweeps every level against every address value and every non-acknowledge function code. After each mismatched cycle it reads `irq_pending_o` back, and the next matching cycle must still be answered. A full sweep of all 256 configured vectors covers the boundary at 64, where the substitution to 15 starts.

// File: rtl/iack_pkg.sv
package iack_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RESP = 1'b1
  } iack_state_e;
endpackage

// File: rtl/iack_pending.sv
module iack_pending (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic pending_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pending_o <= 1'b0;
    else if (set_i)   pending_o <= 1'b1;  // a new request wins over a clear
    else if (clr_i)   pending_o <= 1'b0;
  end

  assert_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> pending_o);
endmodule

// File: rtl/iack_cycle_detect.sv
module iack_cycle_detect #(
  parameter int FC_W    = 3,
  parameter int LVL_W   = 3,
  parameter int FC_IACK = 7
) (
  input  logic [FC_W-1:0]  fc_i,
  input  logic [LVL_W-1:0] lvl_addr_i,
  input  logic             as_ni,
  input  logic             pending_i,
  input  logic [LVL_W-1:0] cfg_level_i,
  output logic             hit_o
);
  logic is_iack, lvl_match;

  assign is_iack   = !as_ni && (fc_i == FC_W'(FC_IACK));
  assign lvl_match = (lvl_addr_i == cfg_level_i) && (cfg_level_i != '0);
  assign hit_o     = is_iack && lvl_match && pending_i;
endmodule

// File: rtl/iack_vector_calc.sv
module iack_vector_calc #(
  parameter int VEC_W        = 8,
  parameter int LVL_W        = 3,
  parameter int USER_VEC_MIN = 64,
  parameter int UNINIT_VEC   = 15,
  parameter int AUTO_BASE    = 24,
  localparam int ADDR_W      = VEC_W + 2
) (
  input  logic             auto_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [VEC_W-1:0] user_vec_i,
  output logic [VEC_W-1:0] vec_num_o,
  output logic [ADDR_W-1:0] vec_addr_o
);
  logic [VEC_W-1:0] user_num, auto_num;

  assign user_num   = (user_vec_i < VEC_W'(USER_VEC_MIN)) ? VEC_W'(UNINIT_VEC) : user_vec_i;
  assign auto_num   = VEC_W'(AUTO_BASE) + VEC_W'(level_i);
  assign vec_num_o  = auto_i ? auto_num : user_num;
  assign vec_addr_o = {vec_num_o, 2'b00};  // long-word table entries
endmodule

// File: rtl/iack_responder.sv
module iack_responder
  import iack_pkg::*;
#(
  parameter int FC_W         = 3,
  parameter int LVL_W        = 3,
  parameter int VEC_W        = 8,
  parameter int FC_IACK      = 7,
  parameter int USER_VEC_MIN = 64,
  parameter int UNINIT_VEC   = 15,
  parameter int AUTO_BASE    = 24,
  localparam int ADDR_W      = VEC_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irq_set_i,
  input  logic [LVL_W-1:0]  cfg_level_i,
  input  logic [VEC_W-1:0]  cfg_vector_i,
  input  logic              cfg_autovec_i,
  input  logic [FC_W-1:0]   fc_i,
  input  logic [LVL_W-1:0]  addr_i,
  input  logic              as_ni,
  output logic [VEC_W-1:0]  data_o,
  output logic              data_oe_o,
  output logic              dtack_no,
  output logic              avec_no,
  output logic              irq_pending_o,
  output logic [VEC_W-1:0]  vec_num_o,
  output logic [ADDR_W-1:0] vec_addr_o
);
  iack_state_e      state_q, state_d;
  logic             hit, resp, clr, auto_q;
  logic [VEC_W-1:0] num_calc, num_q;
  logic [ADDR_W-1:0] addr_calc, addr_q;

  iack_pending u_pending (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (irq_set_i),
    .clr_i     (clr),
    .pending_o (irq_pending_o)
  );

  iack_cycle_detect #(.FC_W(FC_W), .LVL_W(LVL_W), .FC_IACK(FC_IACK)) u_detect (
    .fc_i        (fc_i),
    .lvl_addr_i  (addr_i),
    .as_ni       (as_ni),
    .pending_i   (irq_pending_o),
    .cfg_level_i (cfg_level_i),
    .hit_o       (hit)
  );

  iack_vector_calc #(
    .VEC_W(VEC_W), .LVL_W(LVL_W), .USER_VEC_MIN(USER_VEC_MIN),
    .UNINIT_VEC(UNINIT_VEC), .AUTO_BASE(AUTO_BASE)
  ) u_calc (
    .auto_i     (cfg_autovec_i),
    .level_i    (cfg_level_i),
    .user_vec_i (cfg_vector_i),
    .vec_num_o  (num_calc),
    .vec_addr_o (addr_calc)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (hit)   state_d = ST_RESP;
      ST_RESP: if (as_ni) state_d = ST_IDLE;
      default:            state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      auto_q  <= 1'b0;
      num_q   <= '0;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && hit) begin
        auto_q <= cfg_autovec_i;
        num_q  <= num_calc;
        addr_q <= addr_calc;
      end
    end
  end

  assign resp       = (state_q == ST_RESP);
  assign clr        = resp && as_ni;
  assign dtack_no   = !(resp && !auto_q);
  assign avec_no    = !(resp && auto_q);
  assign data_oe_o  = resp && !auto_q;
  assign data_o     = data_oe_o ? num_q : '0;
  assign vec_num_o  = num_q;
  assign vec_addr_o = addr_q;

  logic strobe;
  assign strobe = !dtack_no || !avec_no;

  assert_one_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({~dtack_no, ~avec_no}));
  assert_oe_with_dtack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> !dtack_no);
  assert_no_oe_on_avec_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !avec_no |-> !data_oe_o);
  assert_start_needs_iack_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe && !$past(strobe)) |-> $past(fc_i == FC_W'(FC_IACK) && !as_ni && addr_i == cfg_level_i));
  assert_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe && as_ni) |=> !strobe);
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe && !as_ni) |=> strobe);
  assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe && as_ni && !irq_set_i) |=> !irq_pending_o);
  assert_vec_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dtack_no |-> (data_o >= VEC_W'(USER_VEC_MIN) || data_o == VEC_W'(UNINIT_VEC)));
  assert_addr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe |-> (vec_addr_o[ADDR_W-1:2] == vec_num_o));
endmodule

// File: tb/iack_responder_test.sv
module iack_responder_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       irq_set_i = 1'b0;
  logic [2:0] cfg_level_i = 3'd0;
  logic [7:0] cfg_vector_i = 8'd0;
  logic       cfg_autovec_i = 1'b0;
  logic [2:0] fc_i = 3'd0;
  logic [2:0] addr_i = 3'd0;
  logic       as_ni = 1'b1;
  logic [7:0] data_o;
  logic       data_oe_o, dtack_no, avec_no, irq_pending_o;
  logic [7:0] vec_num_o;
  logic [9:0] vec_addr_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  iack_responder uut (
    .clk_i, .rst_ni, .irq_set_i, .cfg_level_i, .cfg_vector_i, .cfg_autovec_i,
    .fc_i, .addr_i, .as_ni, .data_o, .data_oe_o, .dtack_no, .avec_no,
    .irq_pending_o, .vec_num_o, .vec_addr_o
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(dtack_no == 1'b1, {tag, " dtack_no"}, int'(dtack_no), 1);
    chk(avec_no == 1'b1, {tag, " avec_no"}, int'(avec_no), 1);
    chk(data_oe_o == 1'b0, {tag, " data_oe_o"}, int'(data_oe_o), 0);
  endtask

  task automatic arm();
    @(negedge clk_i) irq_set_i = 1'b1;
    @(negedge clk_i) irq_set_i = 1'b0;
    chk(irq_pending_o == 1'b1, "R2 pending set", int'(irq_pending_o), 1);
  endtask

  task automatic run_cycle(input logic [2:0] fc, input logic [2:0] a,
                           input bit exp_hit, input bit exp_auto, input int exp_num);
    @(negedge clk_i);
    fc_i = fc; addr_i = a; as_ni = 1'b0;
    #1 chk_idle("R4 before edge");
    @(negedge clk_i);
    if (exp_hit) begin
      if (exp_auto) begin
        chk(avec_no == 1'b0, "R7 avec_no", int'(avec_no), 0);
        chk(dtack_no == 1'b1 && data_oe_o == 1'b0, "R7 no data drive", int'(data_oe_o), 0);
      end else begin
        chk(dtack_no == 1'b0 && avec_no == 1'b1, "R5 dtack_no", int'(dtack_no), 0);
        chk(data_oe_o == 1'b1, "R5 data_oe_o", int'(data_oe_o), 1);
        chk(int'(data_o) == exp_num, "R5/R6 data_o", int'(data_o), exp_num);
      end
      chk(int'(vec_num_o) == exp_num, "R6/R7 vec_num_o", int'(vec_num_o), exp_num);
      chk(int'(vec_addr_o) == exp_num * 4, "R8 vec_addr_o", int'(vec_addr_o), exp_num * 4);
      @(negedge clk_i);
      chk(!dtack_no || !avec_no, "R9 strobe held", int'(dtack_no & avec_no), 0);
    end else begin
      chk_idle("R3 ignored");
      chk(irq_pending_o == 1'b1, "R3 pending kept", int'(irq_pending_o), 1);
    end
    as_ni = 1'b1; fc_i = 3'd0;
    @(negedge clk_i);
    chk_idle("R9 released");
    chk(irq_pending_o == !exp_hit, "R9 pending after cycle", int'(irq_pending_o), int'(!exp_hit));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #1 chk_idle("R1 reset");
    chk(irq_pending_o == 1'b0, "R1 pending", int'(irq_pending_o), 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_idle("R1 after reset");

    // level/address sweep in both modes
    for (int m = 0; m < 2; m++) begin
      for (int lvl = 0; lvl < 8; lvl++) begin
        cfg_level_i = 3'(lvl);
        cfg_autovec_i = m[0];
        cfg_vector_i = 8'(64 + lvl * 9);
        arm();
        for (int a = 0; a < 8; a++) begin
          if (a != lvl || lvl == 0) run_cycle(3'b111, 3'(a), 1'b0, 1'b0, 0);
        end
        if (lvl != 0)
          run_cycle(3'b111, 3'(lvl), 1'b1, m[0], m[0] ? 24 + lvl : 64 + lvl * 9);
        else begin
          @(negedge clk_i) cfg_level_i = 3'd1;
          run_cycle(3'b111, 3'd1, 1'b1, m[0], m[0] ? 25 : 64);
        end
      end
    end

    // non-acknowledge function codes never answer (R3)
    cfg_level_i = 3'd5; cfg_autovec_i = 1'b0; cfg_vector_i = 8'd200;
    arm();
    for (int f = 0; f < 7; f++) run_cycle(3'(f), 3'd5, 1'b0, 1'b0, 0);
    run_cycle(3'b111, 3'd5, 1'b1, 1'b0, 200);

    // full vector sweep, substitution below 64 (R6)
    cfg_level_i = 3'd2;
    for (int v = 0; v < 256; v++) begin
      cfg_vector_i = 8'(v);
      arm();
      run_cycle(3'b111, 3'd2, 1'b1, 1'b0, (v < 64) ? 15 : v);
    end

    // no request pending: matched cycle ignored (R3)
    @(negedge clk_i);
    fc_i = 3'b111; addr_i = 3'd2; as_ni = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    chk_idle("R3 not pending");
    as_ni = 1'b1; fc_i = 3'd0;
    @(negedge clk_i);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule